// File: doc/BRIEF.md
# Memory Access Protection Controller

This block keeps the protection state for a group of on-chip memories and decides, cycle by cycle, whether a request to lift a protection may take effect. It holds four access-protection bits: program code (program flash and test flash together), EEPROM, RAM and the boot/register region. It also holds a parameterised vector of write-protection bits. Every bit reads 1 while its protection is active. On reset each bit reloads from a non-volatile shadow value, which is modelled here as a parameter.

Each request carries a tag naming the memory region that the requesting instruction is fetched from. Protection is lifted through one of two paths. The first is a set-protection operation, which applies a data word under a mask. The second is a direct write to the access register. Each access bit can be lifted through one of these paths only, and only from a fetch region that the bit accepts. A rejected attempt changes nothing and raises a sticky violation flag. Protection can always be raised again with a set-protection operation that writes 0.

The block also gates two read paths, one for the CPU and one for peripheral DMA. A read that targets a protected memory returns all ones instead of the stored data.

Top module: `mem_guard`

## Requirements
- R1: While rstN is low and after its release, accProt equals parameter INIT_ACC, wrProt equals INIT_WP and violation is 0.
- R2: A set-protection cycle (setProt=1) with a mask bit at 1 and its data bit at 0 sets that protection bit to 1 on the next edge, from any fetch region. Bits whose mask is 0 keep their value.
- R3: A set-protection cycle with setWpMask[i]=1 and setWpData[i]=1 clears wrProt[i] from any fetch region. Write-protection clears never raise violation.
- R4: Code bit accProt[0] is cleared only by a set-protection cycle that writes 1 to it with fetchRegion equal to EEPROM (2), RAM (3) or boot (5). Region codes: flash 0, test flash 1, EEPROM 2, RAM 3, external 4, boot 5; codes 6 and 7 name no memory.
- R5: EEPROM bit accProt[1] is cleared only by a set-protection cycle that writes 1 to it with fetchRegion=2.
- R6: RAM bit accProt[2] and boot bit accProt[3] are cleared only by a direct write (dirWr=1, setProt=0) with a 1 in the same bit of dirData and fetchRegion equal to 3 or 5 respectively. Zeros in dirData have no effect.
- R7: Any attempt to clear an access bit that is not permitted leaves accProt unchanged and sets violation. Such an attempt is a 1 in setAccMask&setAccData, or a 1 in dirData. Violation then stays 1 until reset.
- R8: With parameter UNLOCK_EN=0, no access bit ever goes from 1 to 0, and every access clear attempt raises violation.
- R9: dmaRdOut is all ones when dmaRdRegion names a memory whose access bit is 1; otherwise it equals dmaRdIn. Both flash codes map to bit 0, and codes 4, 6 and 7 are never gated.
- R10: cpuRdOut is all ones when cpuRdRegion names a protected memory and fetchRegion does not map to the same access bit; otherwise it equals cpuRdIn.
- R11: When setProt and dirWr are high in the same cycle, the direct write is ignored: it neither clears a bit nor raises violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; reloads the shadow values |
| fetchRegion | input | 3 | Region the requesting instruction is fetched from |
| setProt | input | 1 | Set-protection operation strobe |
| setAccMask | input | 4 | Access bits affected by the operation |
| setAccData | input | 4 | 1 = lift, 0 = raise, for masked access bits |
| setWpMask | input | NUM_WP | Write-protection bits affected |
| setWpData | input | NUM_WP | 1 = lift, 0 = raise, for masked write bits |
| dirWr | input | 1 | Direct write to the access register |
| dirData | input | 4 | Bits to lift by direct write |
| cpuRdRegion | input | 3 | Target region of the CPU read |
| cpuRdIn | input | DATA_W | Raw CPU read data |
| cpuRdOut | output | DATA_W | Gated CPU read data |
| dmaRdRegion | input | 3 | Target region of the DMA read |
| dmaRdIn | input | DATA_W | Raw DMA read data |
| dmaRdOut | output | DATA_W | Gated DMA read data |
| accProt | output | 4 | Access protection: [0] code, [1] EEPROM, [2] RAM, [3] boot |
| wrProt | output | NUM_WP | Write-protection bits |
| violation | output | 1 | Sticky flag for a rejected clear attempt |

## Verification
The bench builds two copies of the block side by side. One copy is built with UNLOCK_EN=1 and all bits protected at reset. The other is built with UNLOCK_EN=0 and mixed shadow values (INIT_ACC=4'b1010, INIT_WP=8'h0F). The first copy brings every accepted and rejected clear path within reach. The second shows that no access bit can fall at all and that a partially open reset state is loaded as given. Both copies see the same random fetch regions, masks and read targets, including the unused region codes. Directed cases cover each bit's proper path and region, the wrong path, and the same-cycle collision of both write paths.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;
  localparam int ACC_W = 4;
  localparam int REG_W = 3;

  localparam int BIT_CODE = 0;
  localparam int BIT_EEP  = 1;
  localparam int BIT_RAM  = 2;
  localparam int BIT_BOOT = 3;

  typedef enum logic [REG_W-1:0] {
    RG_FLASH  = 3'd0,
    RG_TFLASH = 3'd1,
    RG_EEP    = 3'd2,
    RG_RAM    = 3'd3,
    RG_EXT    = 3'd4,
    RG_BOOT   = 3'd5
  } region_e;

  // Which clearing path each access bit accepts.
  localparam logic [ACC_W-1:0] SET_PATH = 4'b0011;
  localparam logic [ACC_W-1:0] DIR_PATH = 4'b1100;

  typedef struct packed {
    logic [ACC_W-1:0] accSet;
    logic [ACC_W-1:0] accClr;
    logic             wpApply;
    logic             violSet;
  } guardStrobe_t;

  typedef struct packed {
    logic       valid;
    logic [1:0] idx;
  } owner_t;

  function automatic owner_t ownerOf(logic [REG_W-1:0] r);
    owner_t o;
    o.valid = 1'b1;
    o.idx   = 2'(BIT_CODE);
    case (r)
      RG_FLASH, RG_TFLASH: o.idx = 2'(BIT_CODE);
      RG_EEP:              o.idx = 2'(BIT_EEP);
      RG_RAM:              o.idx = 2'(BIT_RAM);
      RG_BOOT:             o.idx = 2'(BIT_BOOT);
      default:             o.valid = 1'b0;
    endcase
    return o;
  endfunction

  function automatic logic isInternalData(logic [REG_W-1:0] r);
    return (r == RG_EEP) || (r == RG_RAM) || (r == RG_BOOT);
  endfunction
endpackage

// File: rtl/mem_guard_ctrl.sv
module mem_guard_ctrl
  import mem_guard_pkg::*;
#(
  parameter int NUM_WP    = 8,
  parameter bit UNLOCK_EN = 1'b1
) (
  input  logic [REG_W-1:0]  fetchRegion,
  input  logic              setProt,
  input  logic [ACC_W-1:0]  setAccMask,
  input  logic [ACC_W-1:0]  setAccData,
  input  logic              dirWr,
  input  logic [ACC_W-1:0]  dirData,
  output guardStrobe_t      strobe
);
  logic [ACC_W-1:0] regionOk;
  logic [ACC_W-1:0] setAllow;
  logic [ACC_W-1:0] dirAllow;
  logic [ACC_W-1:0] setClrReq;
  logic [ACC_W-1:0] setRaiseReq;
  owner_t           fetchOwner;

  assign fetchOwner  = ownerOf(fetchRegion);
  assign setClrReq   = setAccMask & setAccData;
  assign setRaiseReq = setAccMask & ~setAccData;

  genvar b;
  generate
    for (b = 0; b < ACC_W; b++) begin : g_allow
      if (b == BIT_CODE) begin : g_code
        assign regionOk[b] = isInternalData(fetchRegion);
      end else begin : g_owner
        assign regionOk[b] = fetchOwner.valid && (fetchOwner.idx == 2'(b));
      end
      assign setAllow[b] = UNLOCK_EN && SET_PATH[b] && regionOk[b];
      assign dirAllow[b] = UNLOCK_EN && DIR_PATH[b] && regionOk[b];
    end
  endgenerate

  always_comb begin
    strobe = '0;
    if (setProt) begin
      strobe.accSet  = setRaiseReq;
      strobe.accClr  = setClrReq & setAllow;
      strobe.wpApply = 1'b1;
      strobe.violSet = |(setClrReq & ~setAllow);
    end else if (dirWr) begin
      strobe.accClr  = dirData & dirAllow;
      strobe.violSet = |(dirData & ~dirAllow);
    end
  end
endmodule

// File: rtl/mem_guard_regs.sv
module mem_guard_regs
  import mem_guard_pkg::*;
#(
  parameter int               NUM_WP   = 8,
  parameter int               DATA_W   = 8,
  parameter logic [3:0]       INIT_ACC = 4'hF,
  parameter logic [NUM_WP-1:0] INIT_WP = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  guardStrobe_t      strobe,
  input  logic [NUM_WP-1:0] setWpMask,
  input  logic [NUM_WP-1:0] setWpData,
  input  logic [REG_W-1:0]  fetchRegion,
  input  logic [REG_W-1:0]  cpuRdRegion,
  input  logic [DATA_W-1:0] cpuRdIn,
  output logic [DATA_W-1:0] cpuRdOut,
  input  logic [REG_W-1:0]  dmaRdRegion,
  input  logic [DATA_W-1:0] dmaRdIn,
  output logic [DATA_W-1:0] dmaRdOut,
  output logic [ACC_W-1:0]  accProt,
  output logic [NUM_WP-1:0] wrProt,
  output logic              violation
);
  logic [ACC_W-1:0]  accQ;
  logic [NUM_WP-1:0] wpQ;
  logic              violQ;
  logic [NUM_WP-1:0] wpRaise;
  logic [NUM_WP-1:0] wpLift;

  assign wpRaise = setWpMask & ~setWpData;
  assign wpLift  = setWpMask & setWpData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= INIT_ACC;
      wpQ   <= INIT_WP;
      violQ <= 1'b0;
    end else begin
      accQ  <= (accQ & ~strobe.accClr) | strobe.accSet;
      if (strobe.wpApply) wpQ <= (wpQ & ~wpLift) | wpRaise;
      violQ <= violQ | strobe.violSet;
    end
  end

  owner_t cpuTgt, dmaTgt, fetchOwn;
  logic   cpuBlock, dmaBlock;

  assign cpuTgt   = ownerOf(cpuRdRegion);
  assign dmaTgt   = ownerOf(dmaRdRegion);
  assign fetchOwn = ownerOf(fetchRegion);

  assign dmaBlock = dmaTgt.valid && accQ[dmaTgt.idx];
  assign cpuBlock = cpuTgt.valid && accQ[cpuTgt.idx] &&
                    !(fetchOwn.valid && fetchOwn.idx == cpuTgt.idx);

  assign dmaRdOut  = dmaBlock ? '1 : dmaRdIn;
  assign cpuRdOut  = cpuBlock ? '1 : cpuRdIn;
  assign accProt   = accQ;
  assign wrProt    = wpQ;
  assign violation = violQ;
endmodule

// File: rtl/mem_guard.sv
module mem_guard
  import mem_guard_pkg::*;
#(
  parameter int                NUM_WP    = 8,
  parameter int                DATA_W    = 8,
  parameter bit                UNLOCK_EN = 1'b1,
  parameter logic [3:0]        INIT_ACC  = 4'hF,
  parameter logic [NUM_WP-1:0] INIT_WP   = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        fetchRegion,
  input  logic              setProt,
  input  logic [3:0]        setAccMask,
  input  logic [3:0]        setAccData,
  input  logic [NUM_WP-1:0] setWpMask,
  input  logic [NUM_WP-1:0] setWpData,
  input  logic              dirWr,
  input  logic [3:0]        dirData,
  input  logic [2:0]        cpuRdRegion,
  input  logic [DATA_W-1:0] cpuRdIn,
  output logic [DATA_W-1:0] cpuRdOut,
  input  logic [2:0]        dmaRdRegion,
  input  logic [DATA_W-1:0] dmaRdIn,
  output logic [DATA_W-1:0] dmaRdOut,
  output logic [3:0]        accProt,
  output logic [NUM_WP-1:0] wrProt,
  output logic              violation
);
  guardStrobe_t strobe;

  mem_guard_ctrl #(.NUM_WP(NUM_WP), .UNLOCK_EN(UNLOCK_EN)) u_ctrl (
    .fetchRegion(fetchRegion), .setProt(setProt),
    .setAccMask(setAccMask), .setAccData(setAccData),
    .dirWr(dirWr), .dirData(dirData), .strobe(strobe)
  );

  mem_guard_regs #(.NUM_WP(NUM_WP), .DATA_W(DATA_W),
                   .INIT_ACC(INIT_ACC), .INIT_WP(INIT_WP)) u_regs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .setWpMask(setWpMask), .setWpData(setWpData),
    .fetchRegion(fetchRegion),
    .cpuRdRegion(cpuRdRegion), .cpuRdIn(cpuRdIn), .cpuRdOut(cpuRdOut),
    .dmaRdRegion(dmaRdRegion), .dmaRdIn(dmaRdIn), .dmaRdOut(dmaRdOut),
    .accProt(accProt), .wrProt(wrProt), .violation(violation)
  );
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
  parameter int NUM_WP    = 8,
  parameter int DATA_W    = 8,
  parameter bit UNLOCK_EN = 1'b1
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        fetchRegion,
  input logic              setProt,
  input logic [3:0]        setAccMask,
  input logic [3:0]        setAccData,
  input logic              dirWr,
  input logic [3:0]        dirData,
  input logic [2:0]        dmaRdRegion,
  input logic [DATA_W-1:0] dmaRdOut,
  input logic [3:0]        accProt,
  input logic              violation
);
  logic dmaTgtProt;
  always_comb begin
    case (dmaRdRegion)
      3'd0, 3'd1: dmaTgtProt = accProt[0];
      3'd2:       dmaTgtProt = accProt[1];
      3'd3:       dmaTgtProt = accProt[2];
      3'd5:       dmaTgtProt = accProt[3];
      default:    dmaTgtProt = 1'b0;
    endcase
  end

  assert_raise_src_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((accProt & ~$past(accProt)) &
     ~({4{$past(setProt)}} & $past(setAccMask) & ~$past(setAccData))) == 4'b0);

  assert_code_open_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accProt[0]) |-> $past(setProt && setAccMask[0] && setAccData[0] &&
      (fetchRegion == 3'd2 || fetchRegion == 3'd3 || fetchRegion == 3'd5)));

  assert_eep_open_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accProt[1]) |-> $past(setProt && setAccMask[1] && setAccData[1] &&
                                fetchRegion == 3'd2));

  assert_ram_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accProt[2]) |-> $past(!setProt && dirWr && dirData[2] && fetchRegion == 3'd3));

  assert_boot_open_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(accProt[3]) |-> $past(!setProt && dirWr && dirData[3] && fetchRegion == 3'd5));

  assert_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    $past(violation) |-> violation);

  assert_dma_gate_R9: assert property (@(posedge clk) disable iff (!rstN)
    dmaTgtProt |-> (dmaRdOut == {DATA_W{1'b1}}));

  assert_collide_R11: assert property (@(posedge clk) disable iff (!rstN)
    (setProt && dirWr && setAccMask[3:2] == 2'b00) |=> $stable(accProt[3:2]));

  generate
    if (!UNLOCK_EN) begin : g_locked
      assert_never_open_R8: assert property (@(posedge clk) disable iff (!rstN)
        ($past(accProt) & ~accProt) == 4'b0);
    end
  endgenerate
endmodule

bind mem_guard mem_guard_chk #(.NUM_WP(NUM_WP), .DATA_W(DATA_W), .UNLOCK_EN(UNLOCK_EN)) u_chk (
  .clk(clk), .rstN(rstN), .fetchRegion(fetchRegion), .setProt(setProt),
  .setAccMask(setAccMask), .setAccData(setAccData), .dirWr(dirWr), .dirData(dirData),
  .dmaRdRegion(dmaRdRegion), .dmaRdOut(dmaRdOut), .accProt(accProt), .violation(violation)
);

// File: tb/mem_guard_tb.sv
module mem_guard_tb;
  localparam int NUM_WP = 8;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [2:0]        fetchRegion = '0;
  logic              setProt = 1'b0;
  logic [3:0]        setAccMask = '0, setAccData = '0;
  logic [NUM_WP-1:0] setWpMask = '0, setWpData = '0;
  logic              dirWr = 1'b0;
  logic [3:0]        dirData = '0;
  logic [2:0]        cpuRdRegion = '0, dmaRdRegion = '0;
  logic [DATA_W-1:0] cpuRdIn = '0, dmaRdIn = '0;

  logic [DATA_W-1:0] cpuOut[2], dmaOut[2];
  logic [3:0]        accOut[2];
  logic [NUM_WP-1:0] wpOut[2];
  logic              violOut[2];

  mem_guard #(.NUM_WP(NUM_WP), .DATA_W(DATA_W), .UNLOCK_EN(1'b1),
              .INIT_ACC(4'hF), .INIT_WP(8'hFF)) u_dut (
    .clk(clk), .rstN(rstN), .fetchRegion(fetchRegion), .setProt(setProt),
    .setAccMask(setAccMask), .setAccData(setAccData),
    .setWpMask(setWpMask), .setWpData(setWpData), .dirWr(dirWr), .dirData(dirData),
    .cpuRdRegion(cpuRdRegion), .cpuRdIn(cpuRdIn), .cpuRdOut(cpuOut[0]),
    .dmaRdRegion(dmaRdRegion), .dmaRdIn(dmaRdIn), .dmaRdOut(dmaOut[0]),
    .accProt(accOut[0]), .wrProt(wpOut[0]), .violation(violOut[0]));

  mem_guard #(.NUM_WP(NUM_WP), .DATA_W(DATA_W), .UNLOCK_EN(1'b0),
              .INIT_ACC(4'b1010), .INIT_WP(8'h0F)) u_dutLocked (
    .clk(clk), .rstN(rstN), .fetchRegion(fetchRegion), .setProt(setProt),
    .setAccMask(setAccMask), .setAccData(setAccData),
    .setWpMask(setWpMask), .setWpData(setWpData), .dirWr(dirWr), .dirData(dirData),
    .cpuRdRegion(cpuRdRegion), .cpuRdIn(cpuRdIn), .cpuRdOut(cpuOut[1]),
    .dmaRdRegion(dmaRdRegion), .dmaRdIn(dmaRdIn), .dmaRdOut(dmaOut[1]),
    .accProt(accOut[1]), .wrProt(wpOut[1]), .violation(violOut[1]));

  int checks = 0;
  int errors = 0;
  logic [3:0]        mAcc[2];
  logic [NUM_WP-1:0] mWp[2];
  logic              mViol[2];
  bit                unl[2] = '{1'b1, 1'b0};
  logic [3:0]        initAcc[2] = '{4'hF, 4'b1010};
  logic [NUM_WP-1:0] initWp[2] = '{8'hFF, 8'h0F};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Access bit index a region maps to; -1 when it names no memory.
  function automatic int bitOf(logic [2:0] r);
    case (r)
      3'd0, 3'd1: return 0;
      3'd2: return 1;
      3'd3: return 2;
      3'd5: return 3;
      default: return -1;
    endcase
  endfunction

  function automatic bit mayClear(int d, int b, logic [2:0] f, bit viaSet);
    if (!unl[d]) return 0;
    case (b)
      0: return viaSet && (f == 3'd2 || f == 3'd3 || f == 3'd5);
      1: return viaSet && f == 3'd2;
      2: return !viaSet && f == 3'd3;
      default: return !viaSet && f == 3'd5;
    endcase
  endfunction

  task automatic modelStep();
    for (int d = 0; d < 2; d++) begin
      if (setProt) begin
        for (int b = 0; b < 4; b++) if (setAccMask[b]) begin
          if (!setAccData[b]) mAcc[d][b] = 1'b1;
          else if (mayClear(d, b, fetchRegion, 1)) mAcc[d][b] = 1'b0;
          else mViol[d] = 1'b1;
        end
        for (int i = 0; i < NUM_WP; i++) if (setWpMask[i]) mWp[d][i] = !setWpData[i];
      end else if (dirWr) begin
        for (int b = 0; b < 4; b++) if (dirData[b]) begin
          if (mayClear(d, b, fetchRegion, 0)) mAcc[d][b] = 1'b0;
          else mViol[d] = 1'b1;
        end
      end
    end
  endtask

  task automatic checkState(string tag);
    for (int d = 0; d < 2; d++) begin
      check({tag, " accProt"}, 32'(accOut[d]), 32'(mAcc[d]));
      check({tag, " wrProt"}, 32'(wpOut[d]), 32'(mWp[d]));
      check({tag, " violation"}, 32'(violOut[d]), 32'(mViol[d]));
    end
  endtask

  task automatic checkReads();
    for (int d = 0; d < 2; d++) begin
      int t = bitOf(dmaRdRegion);
      int c = bitOf(cpuRdRegion);
      logic [DATA_W-1:0] expD = (t >= 0 && mAcc[d][t]) ? '1 : dmaRdIn;
      logic [DATA_W-1:0] expC = (c >= 0 && mAcc[d][c] && bitOf(fetchRegion) != c) ? '1 : cpuRdIn;
      check("R9 dma read", 32'(dmaOut[d]), 32'(expD));
      check("R10 cpu read", 32'(cpuOut[d]), 32'(expC));
    end
  endtask

  task automatic doOp(string tag, logic [2:0] f, bit sp, logic [3:0] m, logic [3:0] dt,
                      logic [NUM_WP-1:0] wm, logic [NUM_WP-1:0] wd, bit dw, logic [3:0] dd);
    @(negedge clk);
    fetchRegion = f; setProt = sp; setAccMask = m; setAccData = dt;
    setWpMask = wm; setWpData = wd; dirWr = dw; dirData = dd;
    modelStep();
    @(negedge clk);
    setProt = 1'b0; dirWr = 1'b0;
    checkState(tag);
    cpuRdRegion = 3'($urandom_range(0, 7)); dmaRdRegion = 3'($urandom_range(0, 7));
    cpuRdIn = DATA_W'($urandom); dmaRdIn = DATA_W'($urandom);
    #2 checkReads();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    for (int d = 0; d < 2; d++) begin
      mAcc[d] = initAcc[d]; mWp[d] = initWp[d]; mViol[d] = 1'b0;
    end
    repeat (2) @(negedge clk);
    checkState("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    checkState("R1 after reset");
  endtask

  initial begin
    void'($urandom(32'h5EED));
    doReset();
    // R4: code bit from flash rejected, from RAM accepted
    doOp("R4 from flash", 3'd0, 1, 4'b0001, 4'b0001, '0, '0, 0, '0);
    doOp("R4 from RAM", 3'd3, 1, 4'b0001, 4'b0001, '0, '0, 0, '0);
    // R5: EEPROM bit from RAM rejected, from EEPROM accepted
    doOp("R5 from RAM", 3'd3, 1, 4'b0010, 4'b0010, '0, '0, 0, '0);
    doOp("R5 from EEPROM", 3'd2, 1, 4'b0010, 4'b0010, '0, '0, 0, '0);
    doReset();
    // R6: RAM/boot bits by direct write from themselves; set op path rejected
    doOp("R6 ram via set", 3'd3, 1, 4'b0100, 4'b0100, '0, '0, 0, '0);
    doReset();
    doOp("R6 ram direct", 3'd3, 0, '0, '0, '0, '0, 1, 4'b0100);
    doOp("R6 boot direct", 3'd5, 0, '0, '0, '0, '0, 1, 4'b1000);
    doOp("R7 boot from ext", 3'd4, 0, '0, '0, '0, '0, 1, 4'b1000);
    doOp("R2 raise all", 3'd4, 1, 4'hF, 4'h0, 8'hF0, 8'h00, 0, '0);
    doOp("R3 wp lift", 3'd7, 1, 4'h0, 4'h0, 8'hFF, 8'h5A, 0, '0);
    doReset();
    doOp("R11 collide", 3'd3, 1, 4'b0000, 4'b0000, '0, '0, 1, 4'b0100);
    doOp("R11 collide boot", 3'd5, 1, 4'b0001, 4'b0001, '0, '0, 1, 4'b1000);
    for (int n = 0; n < 600; n++) begin
      bit sp = ($urandom_range(0, 2) == 0);
      bit dw = ($urandom_range(0, 2) == 0);
      if (n % 150 == 149) doReset();
      doOp("R2 R3 R4 R5 R6 R7 R8 R11 random", 3'($urandom_range(0, 7)), sp,
           4'($urandom), 4'($urandom), NUM_WP'($urandom), NUM_WP'($urandom),
           dw, 4'($urandom));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule